// File: doc/BRIEF.md
# Serial-Controlled 32-Way Switch Selector

This block is the digital control core of a 32-to-1 analog switch array. A host writes an 8-bit command over three wires: an active-low frame strobe, a serial clock and a data line. The block samples those pins with its own fast system clock and detects the falling serial-clock edges. It shifts in eight data bits per frame and decodes the resulting command. It then drives 32 switch-enable outputs, of which at most one is ever high.

The command can close one channel, open every channel, or leave the switches untouched. When one channel is replaced by another, the outputs pass through a programmable number of system-clock cycles with every enable low before the new one rises. The old switch therefore opens before the new one closes. The update fires on the eighth falling serial-clock edge, whether or not the frame strobe has returned high.

Top module: `serial_switch_sel`

## Requirements
- R1: After reset every `sw_en` bit is low, and it stays low until a complete eight-bit write arrives.
- R2: Data is taken on falling edges of `sclk`, most significant bit first. In the command byte, bit 7 is the all-off flag, bit 6 is the active-low select flag, bit 5 has no effect, and bits 4..0 form the channel number.
- R3: A command with bit 7 = 0 and bit 6 = 0 and channel number n drives `sw_en[n]` high and every other bit low.
- R4: A command with bit 7 = 1 and bit 6 = 0 drives every `sw_en` bit low.
- R5: A command with bit 6 = 1 leaves `sw_en` unchanged, and this holds even when bit 7 is also 1.
- R6: The command takes effect after the eighth falling edge even while `frame_n` is still low. Further falling edges in that frame are ignored until `frame_n` goes high and then low again.
- R7: A frame in which `frame_n` returns high after fewer than eight falling edges is dropped and leaves `sw_en` unchanged.
- R8: When the output moves to a new channel, `sw_en` is all low for exactly GAP_CYC system clocks before the new bit rises, and two bits are never high at once.
- R9: A select command naming the channel that is already on causes no gap and no change on `sw_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| sclk | input | 1 | Serial clock from the host; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| sw_en | output | NUM_CH (32) | Switch enables, at most one high |

## Verification
The hardest situation to reach from the ports is a frame in which the strobe stays low past the eighth edge while more edges keep arriving, because a normal host always closes the frame. The stimulus therefore drives the three wires bit by bit from tasks that hold the strobe low and clock a second full byte into the same frame. It also cuts frames short after five edges. The gap rule is tested by moving between two live channels, which leaves the all-low window visible between them, and by reselecting the channel already on, where no such window may appear.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

    typedef enum logic [1:0] {
        ACT_RETAIN = 2'd0,
        ACT_OFF    = 2'd1,
        ACT_SELECT = 2'd2
    } ssel_act_e;

endpackage

// File: rtl/ssel_sync.sv
module ssel_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/ssel_frame.sv
module ssel_frame #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_s_n,
    input  logic             sclk_s,
    input  logic             sdin_s,
    output logic             cmd_vld,
    output logic [CMD_W-1:0] cmd_word
);

    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_W - 1);

    typedef struct packed {
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [CMD_W-1:0] shreg;
        logic             vld;
        logic [CMD_W-1:0] word;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic      fall;
    logic [CMD_W-1:0] shifted;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.sclk_prev = sclk_s;
        fall           = st_q.sclk_prev & ~sclk_s;
        shifted        = {st_q.shreg[CMD_W-2:0], sdin_s};
        if (frame_s_n) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done && fall) begin
            st_d.shreg = shifted;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt  = '0;
                st_d.done = 1'b1;
                st_d.vld  = 1'b1;
                st_d.word = shifted;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_vld  = st_q.vld;
    assign cmd_word = st_q.word;

endmodule

// File: rtl/ssel_decode.sv
module ssel_decode
    import ssel_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 5
) (
    input  logic [CMD_W-1:0]  cmd_word,
    output ssel_act_e         act,
    output logic [ADDR_W-1:0] addr
);

    localparam int OFF_BIT  = CMD_W - 1;
    localparam int HOLD_BIT = CMD_W - 2;

    always_comb begin
        addr = cmd_word[ADDR_W-1:0];
        if (cmd_word[HOLD_BIT]) begin
            act = ACT_RETAIN;
        end else if (cmd_word[OFF_BIT]) begin
            act = ACT_OFF;
        end else if (32'(addr) >= 32'(NUM_CH)) begin
            act = ACT_OFF;
        end else begin
            act = ACT_SELECT;
        end
    end

endmodule

// File: rtl/ssel_bbm.sv
module ssel_bbm
    import ssel_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 5,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  ssel_act_e         act,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] sw_en
);

    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0] out;
        logic              in_gap;
        logic [GW-1:0]     cnt;
        logic [ADDR_W-1:0] tgt;
    } bbm_st_t;

    bbm_st_t st_d, st_q;
    logic [NUM_CH-1:0] addr_hot, tgt_hot;

    always_comb begin
        addr_hot = '0;
        tgt_hot  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (32'(addr) == 32'(i))     addr_hot[i] = 1'b1;
            if (32'(st_q.tgt) == 32'(i)) tgt_hot[i]  = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (cmd_vld && act == ACT_OFF) begin
            st_d.out    = '0;
            st_d.in_gap = 1'b0;
            st_d.cnt    = '0;
        end else if (cmd_vld && act == ACT_SELECT) begin
            if (!(!st_q.in_gap && st_q.out == addr_hot)) begin
                st_d.out    = '0;
                st_d.in_gap = 1'b1;
                st_d.cnt    = GW'(GAP_CYC - 1);
                st_d.tgt    = addr;
            end
        end else if (st_q.in_gap) begin
            if (st_q.cnt == '0) begin
                st_d.out    = tgt_hot;
                st_d.in_gap = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_en = st_q.out;

endmodule

// File: rtl/serial_switch_sel.sv
module serial_switch_sel
    import ssel_pkg::*;
#(
    parameter int NUM_CH      = 32,
    parameter int CMD_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [NUM_CH-1:0] sw_en
);

    localparam int ADDR_W = $clog2(NUM_CH);

    logic [2:0]       pins_s;
    logic             cmd_vld;
    logic [CMD_W-1:0] cmd_word;
    ssel_act_e        act;
    logic [ADDR_W-1:0] addr;

    ssel_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({frame_n, sclk, sdin}),
        .q     (pins_s)
    );

    ssel_frame #(
        .CMD_W (CMD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_s_n (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .sdin_s    (pins_s[0]),
        .cmd_vld   (cmd_vld),
        .cmd_word  (cmd_word)
    );

    ssel_decode #(
        .CMD_W  (CMD_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .cmd_word (cmd_word),
        .act      (act),
        .addr     (addr)
    );

    ssel_bbm #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .GAP_CYC (GAP_CYC)
    ) u_bbm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_vld (cmd_vld),
        .act     (act),
        .addr    (addr),
        .sw_en   (sw_en)
    );

endmodule

// File: rtl/ssel_checker.sv
module ssel_checker #(
    parameter int NUM_CH  = 32,
    parameter int GAP_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] sw_en,
    input logic              cmd_vld
);

    localparam int ZW = $clog2(GAP_CYC + 2);
    localparam logic [ZW-1:0] ZMAX = ZW'(GAP_CYC + 1);

    logic [ZW-1:0] zero_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              zero_run <= ZMAX;
        else if (sw_en != '0)    zero_run <= '0;
        else if (zero_run != ZMAX) zero_run <= zero_run + 1'b1;
    end

    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_en)); // R8

    AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_en) != '0 && sw_en != '0) |-> sw_en == $past(sw_en)); // R8

    AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_en) == '0 && sw_en != '0) |-> zero_run >= ZW'(GAP_CYC)); // R8

    AST_OPEN_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_en) != '0 && sw_en == '0) |-> $past(cmd_vld)); // R7

    AST_ONE_CMD_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> !cmd_vld); // R6

endmodule

bind serial_switch_sel ssel_checker #(
    .NUM_CH  (NUM_CH),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_en   (sw_en),
    .cmd_vld (cmd_vld)
);

// File: tb/serial_switch_sel_tb.sv
`timescale 1ns/1ps
module serial_switch_sel_tb;

    localparam int NUM_CH  = 32;
    localparam int GAP_CYC = 2;
    localparam int HALF    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic [NUM_CH-1:0] sw_en;

    int checks = 0;
    int fails = 0;
    int zcount = 0;
    bit finished = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    serial_switch_sel #(.NUM_CH(NUM_CH), .GAP_CYC(GAP_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
        .sclk(sclk), .sdin(sdin), .sw_en(sw_en)
    );

    // behavioural reference model
    bit qs[$], qf[$], qd[$];
    bit [7:0] m_sh, m_word;
    int m_cnt, m_rem, m_cur, m_tgt;
    bit m_done, m_vld;
    logic [NUM_CH-1:0] m_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            qs = '{0, 0, 0, 0}; qf = '{1, 1, 1, 1}; qd = '{0, 0, 0, 0};
            m_sh = 0; m_word = 0; m_cnt = 0; m_rem = 0; m_cur = -1; m_tgt = 0;
            m_done = 0; m_vld = 0; m_out = '0;
        end else begin
            bit old_vld;
            bit [7:0] old_word;
            qs.push_front(sclk); qf.push_front(frame_n); qd.push_front(sdin);
            void'(qs.pop_back()); void'(qf.pop_back()); void'(qd.pop_back());
            old_vld = m_vld; old_word = m_word;
            m_vld = 0;
            if (qf[2]) begin
                m_cnt = 0; m_done = 0;
            end else if (!m_done && qs[3] && !qs[2]) begin
                m_sh = {m_sh[6:0], qd[2]};
                m_cnt++;
                if (m_cnt == 8) begin
                    m_cnt = 0; m_done = 1; m_vld = 1; m_word = m_sh;
                end
            end
            if (old_vld && !old_word[6]) begin
                if (old_word[7]) begin
                    m_out = '0; m_cur = -1; m_rem = 0;
                end else if (!(m_rem == 0 && m_cur == int'(old_word[4:0]))) begin
                    m_out = '0; m_cur = -1; m_rem = GAP_CYC; m_tgt = old_word[4:0];
                end
            end else if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_out = '0; m_out[m_tgt] = 1'b1; m_cur = m_tgt;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (sw_en !== m_out) begin
                fails++;
                $display("FAIL %s model compare: actual %h expected %h", cur_tag, sw_en, m_out);
            end
            if (sw_en == '0) zcount++;
        end
    end

    task automatic check(input string tag, input logic [NUM_CH-1:0] act, input logic [NUM_CH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fs_low();
        @(negedge clk); frame_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic fs_high();
        wait_clk(HALF); frame_n = 1'b1; wait_clk(2 * HALF);
    endtask

    task automatic shift_bits(input bit [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sdin = b[7-i];
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
    endtask

    task automatic write(input bit [7:0] b);
        fs_low(); shift_bits(b, 8); fs_high(); wait_clk(4);
    endtask

    function automatic logic [NUM_CH-1:0] hot(input int n);
        logic [NUM_CH-1:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin
        int z0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 reset state", sw_en, '0);

        cur_tag = "R1";
        fs_low(); shift_bits(8'h05, 7); fs_high();
        check("R1 seven edges leave outputs off", sw_en, '0);

        cur_tag = "R3";
        write(8'h05);
        check("R3 select channel 5", sw_en, hot(5));

        cur_tag = "R8";
        z0 = zcount;
        write(8'h1F);
        check("R3 select channel 31", sw_en, hot(31));
        check_int("R8 gap length 5 to 31", zcount - z0, GAP_CYC);

        cur_tag = "R2";
        write(8'h10);
        check("R2 msb first gives channel 16", sw_en, hot(16));
        write(8'h20);
        check("R2 bit 5 ignored gives channel 0", sw_en, hot(0));

        cur_tag = "R5";
        write(8'h43);
        check("R5 hold flag keeps channel 0", sw_en, hot(0));
        write(8'hC0);
        check("R5 hold beats off flag", sw_en, hot(0));

        cur_tag = "R4";
        write(8'h9B);
        check("R4 off flag opens all", sw_en, '0);
        write(8'h07);
        check("R3 select channel 7 from off", sw_en, hot(7));

        cur_tag = "R9";
        z0 = zcount;
        write(8'h07);
        check("R9 reselect keeps channel 7", sw_en, hot(7));
        check_int("R9 no gap on reselect", zcount - z0, 0);

        cur_tag = "R7";
        fs_low(); shift_bits(8'h0C, 5); fs_high(); wait_clk(4);
        check("R7 short frame dropped", sw_en, hot(7));
        fs_low(); shift_bits(8'h80, 3); fs_high(); wait_clk(4);
        check("R7 short off frame dropped", sw_en, hot(7));

        cur_tag = "R6";
        fs_low(); shift_bits(8'h02, 8); wait_clk(8);
        check("R6 update while frame low", sw_en, hot(2));
        shift_bits(8'h0A, 8); wait_clk(8);
        check("R6 extra edges ignored", sw_en, hot(2));
        fs_high(); wait_clk(4);
        write(8'h0A);
        check("R6 new frame after release", sw_en, hot(10));

        cur_tag = "R8";
        z0 = zcount;
        write(8'h00);
        check("R8 move to channel 0", sw_en, hot(0));
        check_int("R8 gap length 10 to 0", zcount - z0, GAP_CYC);

        wait_clk(5);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule